// File: doc/BRIEF.md
# Programmable Interrupt Delay Counter

This block is a host-loaded down counter that raises an interrupt request once a programmed delay has run out. The host writes a count value through a simple write strobe and data port. An internal prescaler turns the system clock into a count tick. A speed-select input picks a short tick period for fast links or a tick ten times longer for slow links. Because the tick period matches four byte times at the chosen link rate, the host can convert between byte times and count values with shifts alone.

A mode input decides when counting starts. In immediate mode the counter starts on the write. In deferred mode the written value is held until a transmit-DMA-complete event arrives. The interrupt-enable status bit is managed only by hardware. A nonzero write sets it and a zero write clears it. It also clears itself when the request fires, so every nonzero write produces at most one request. Writing zero cancels a pending timeout.

Top module: `intr_countdown`

## Requirements
- R1: A write of a nonzero value loads that value into the count and sets the interrupt-enable status, both visible in the cycle after the write strobe.
- R2: A write of zero sets the count to 0 and clears the interrupt-enable status in the cycle after the strobe. No interrupt request follows, including for a count that was already running.
- R3: In immediate mode (mode input 0), counting starts at the write. The count falls by exactly one every DIV clock cycles, and the first decrement lands DIV cycles after the write edge.
- R4: DIV is FAST_DIV cycles when the speed input is 1 and SLOW_DIV cycles when it is 0. The defaults are 8 and 80, which give 320 ns and 3.2 µs at a 25 MHz clock.
- R5: In deferred mode (mode input 1), a nonzero written value is held unchanged until the transmit-DMA-complete input is sampled high. Counting then starts, with the first decrement DIV cycles after that edge.
- R6: When the count passes from 1 to 0, the interrupt-request pulse is high for exactly one cycle: the first cycle in which the count reads 0. The interrupt-enable status reads 0 from that same cycle.
- R7: Once the count is 0 it stays 0 until the next write, with no further requests, whatever the transmit-DMA-complete input does.
- R8: A write during an active count or wait loads the new value and restarts the prescaler. In deferred mode it also returns the counter to waiting for a new transmit-DMA-complete event.
- R9: The transmit-DMA-complete input has no effect in immediate mode or while a count is already running. The count timing continues unchanged.
- R10: When a write and a transmit-DMA-complete event occur in the same cycle, the write takes effect and the event is dropped. A deferred write therefore waits for a later event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the count value |
| wr_data | input | CNT_W | Count value to load |
| speed_fast | input | 1 | 1 selects the short tick period, 0 the long one |
| defer_mode | input | 1 | 1 holds the count until transmit DMA completes |
| tx_dma_done | input | 1 | Single-cycle transmit-DMA-complete event |
| count | output | CNT_W | Current count value |
| irq_enable | output | 1 | Hardware-managed interrupt-enable status |
| irq_set | output | 1 | One-cycle interrupt-request set pulse |

## Verification
The bench builds the block with CNT_W=8, FAST_DIV=4 and SLOW_DIV=10. These small dividers bring many full countdowns, in both speeds and both modes, within a short run. Every decrement edge and the single request cycle can be compared against counts of DIV computed in the bench. The 8-bit width puts the largest loadable value, 255, within reach as a boundary case. Random trials mix value, speed, mode, event delay and stray events. Directed cases cover a cancelling zero write, rewrites in both modes, and a write colliding with the event.

// File: rtl/intr_countdown_pkg.sv
package intr_countdown_pkg;
  typedef enum logic [1:0] {
    CD_IDLE = 2'd0,
    CD_WAIT = 2'd1,
    CD_RUN  = 2'd2
  } cd_state_e;
endpackage

// File: rtl/cd_prescaler.sv
module cd_prescaler #(
  parameter int FAST_DIV = 8,
  parameter int SLOW_DIV = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic speed_fast,
  output logic tick
);
  localparam int MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int PW = $clog2(MAXDIV + 1);
  localparam logic [PW-1:0] FAST_LIM = PW'(FAST_DIV - 1);
  localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_DIV - 1);

  logic [PW-1:0] phase;
  logic [PW-1:0] limit;

  // A compare of >= keeps a speed switch mid-period from overrunning the limit
  assign limit = speed_fast ? FAST_LIM : SLOW_LIM;
  assign tick  = run && !clear && (phase >= limit);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      phase <= '0;
    end else if (phase >= limit) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/cd_arm_fsm.sv
module cd_arm_fsm
  import intr_countdown_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_nonzero,
  input  logic defer_mode,
  input  logic tx_dma_done,
  input  logic expire,
  output logic run
);
  cd_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    if (wr_en) begin
      if (!wr_nonzero)     state_nx = CD_IDLE;
      else if (defer_mode) state_nx = CD_WAIT;
      else                 state_nx = CD_RUN;
    end else begin
      case (state)
        CD_WAIT: if (tx_dma_done) state_nx = CD_RUN;
        CD_RUN:  if (expire)      state_nx = CD_IDLE;
        default: state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= CD_IDLE;
    else     state <= state_nx;
  end

  assign run = (state == CD_RUN);
endmodule

// File: rtl/cd_counter.sv
module cd_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             irq_enable,
  output logic             irq_set,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = tick && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      irq_enable <= 1'b0;
      irq_set    <= 1'b0;
    end else if (wr_en) begin
      count      <= wr_data;
      irq_enable <= |wr_data;
      irq_set    <= 1'b0;
    end else if (tick && count != '0) begin
      count   <= count - ONE;
      irq_set <= expire && irq_enable;
      if (expire) irq_enable <= 1'b0;
    end else begin
      irq_set <= 1'b0;
    end
  end
endmodule

// File: rtl/intr_countdown.sv
module intr_countdown #(
  parameter int CNT_W    = 16,
  parameter int FAST_DIV = 8,
  parameter int SLOW_DIV = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             speed_fast,
  input  logic             defer_mode,
  input  logic             tx_dma_done,
  output logic [CNT_W-1:0] count,
  output logic             irq_enable,
  output logic             irq_set
);
  logic run;
  logic tick;
  logic expire;

  cd_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst(rst), .clear(wr_en), .run(run),
    .speed_fast(speed_fast), .tick(tick)
  );

  cd_arm_fsm u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_nonzero(|wr_data),
    .defer_mode(defer_mode), .tx_dma_done(tx_dma_done),
    .expire(expire), .run(run)
  );

  cd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
    .count(count), .irq_enable(irq_enable), .irq_set(irq_set),
    .expire(expire)
  );
endmodule

// File: rtl/intr_countdown_chk.sv
module intr_countdown_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count,
  input logic             irq_enable,
  input logic             irq_set
);
  assert_load_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data != '0) |=> (irq_enable && count == $past(wr_data)));

  assert_zero_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == '0) |=> (!irq_enable && count == '0 && !irq_set));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (count == $past(count) || count == $past(count) - CNT_W'(1)));

  assert_irq_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
    irq_set |-> (count == '0 && !irq_enable));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
    irq_set |=> !irq_set);

  assert_irq_from_one_R6: assert property (@(posedge clk) disable iff (rst)
    irq_set |-> ($past(count) == CNT_W'(1)));

  assert_zero_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && count == '0) |=> (count == '0 && !irq_set));
endmodule

bind intr_countdown intr_countdown_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .count(count), .irq_enable(irq_enable), .irq_set(irq_set)
);

// File: tb/sim_intr_countdown.sv
module sim_intr_countdown;
  localparam int CW = 8;
  localparam int FD = 4;
  localparam int SD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic          speed_fast = 1'b0;
  logic          defer_mode = 1'b0;
  logic          tx_dma_done = 1'b0;
  logic [CW-1:0] count;
  logic          irq_enable;
  logic          irq_set;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  intr_countdown #(.CNT_W(CW), .FAST_DIV(FD), .SLOW_DIV(SD)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .speed_fast(speed_fast), .defer_mode(defer_mode),
    .tx_dma_done(tx_dma_done), .count(count),
    .irq_enable(irq_enable), .irq_set(irq_set)
  );

  function automatic int div_of(bit fast);
    return fast ? FD : SD;
  endfunction

  // expected count k edges after counting starts
  function automatic int exp_count(int n, int dv, int k);
    int v = n - k / dv;
    return (v < 0) ? 0 : v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(int val, bit dfr, bit fast, bit with_tx);
    wr_en = 1'b1; wr_data = CW'(val); defer_mode = dfr; speed_fast = fast;
    tx_dma_done = with_tx;
    @(negedge clk);
    wr_en = 1'b0; tx_dma_done = 1'b0;
    if (val != 0) chk(irq_enable && count == CW'(val), "R1", int'(count), val);
    else chk(!irq_enable && count == 0 && !irq_set, "R2", int'(count), 0);
  endtask

  // count held for cyc cycles while waiting
  task automatic hold_check(int n, int cyc, string req);
    bit ok = 1'b1;
    int bad = n;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (count != CW'(n) || irq_set) begin ok = 1'b0; bad = int'(count); end
    end
    chk(ok, req, bad, n);
  endtask

  task automatic fire_tx();
    tx_dma_done = 1'b1;
    @(negedge clk);
    tx_dma_done = 1'b0;
  endtask

  // runs a full countdown started at the last edge; stray_at pulses tx (R9)
  task automatic run_check(int n, bit fast, int stray_at, string req);
    int dv = div_of(fast);
    int total = n * dv;
    bit cnt_ok = 1'b1, irq_ok = 1'b1, post_ok = 1'b1;
    int bad_act = 0, bad_exp = 0, irq_seen = -1;
    for (int k = 1; k <= total + 4; k++) begin
      @(negedge clk);
      if (int'(count) != exp_count(n, dv, k)) begin
        cnt_ok = 1'b0; bad_act = int'(count); bad_exp = exp_count(n, dv, k);
      end
      if (irq_set) begin
        if (irq_seen < 0) irq_seen = k;
        if (k != total) irq_ok = 1'b0;
      end
      if (k == total && (!irq_set || irq_enable)) irq_ok = 1'b0;
      if (k > total && (count != 0 || irq_enable || irq_set)) post_ok = 1'b0;
      tx_dma_done = (k == stray_at || k > total);
    end
    tx_dma_done = 1'b0;
    chk(cnt_ok, fast ? "R4 fast" : "R4 slow", bad_act, bad_exp);
    chk(cnt_ok, req, bad_act, bad_exp);
    chk(irq_ok, "R6", irq_seen, total);
    chk(post_ok, "R7", int'(count), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(count == 0 && !irq_enable && !irq_set, "reset", int'(count), 0);

    // R3 immediate, both speeds, boundary values
    do_write(1, 1'b0, 1'b1, 1'b0);   run_check(1, 1'b1, 0, "R3");
    do_write(1, 1'b0, 1'b0, 1'b0);   run_check(1, 1'b0, 0, "R3");
    do_write(255, 1'b0, 1'b1, 1'b0); run_check(255, 1'b1, 0, "R3");

    // R5 deferred start
    do_write(6, 1'b1, 1'b0, 1'b0);
    hold_check(6, 37, "R5");
    fire_tx();
    run_check(6, 1'b0, 0, "R5");

    // R9 stray event in immediate mode
    do_write(5, 1'b0, 1'b1, 1'b0);
    run_check(5, 1'b1, 3, "R9");

    // R2 zero write cancels a running count
    do_write(7, 1'b0, 1'b1, 1'b0);
    repeat (6) @(negedge clk);
    do_write(0, 1'b0, 1'b1, 1'b0);
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        tx_dma_done = (i == 5);
        if (count != 0 || irq_enable || irq_set) ok = 1'b0;
      end
      tx_dma_done = 1'b0;
      chk(ok, "R2 cancel", int'(count), 0);
    end

    // R8 immediate rewrite restarts prescaler
    do_write(9, 1'b0, 1'b0, 1'b0);
    repeat (23) @(negedge clk);
    do_write(3, 1'b0, 1'b0, 1'b0);
    run_check(3, 1'b0, 0, "R8");

    // R8 deferred rewrite re-arms the wait
    do_write(4, 1'b1, 1'b1, 1'b0);
    fire_tx();
    repeat (6) @(negedge clk);
    do_write(8, 1'b1, 1'b1, 1'b0);
    hold_check(8, 20, "R8 rearm");
    fire_tx();
    run_check(8, 1'b1, 0, "R8");

    // R10 write colliding with event
    do_write(2, 1'b1, 1'b1, 1'b1);
    hold_check(2, 15, "R10");
    fire_tx();
    run_check(2, 1'b1, 0, "R10");

    // random trials
    for (int t = 0; t < 40; t++) begin
      int n = 1 + int'($urandom % 20);
      bit dfr = 1'($urandom);
      bit fst = 1'($urandom);
      do_write(n, dfr, fst, 1'b0);
      if (dfr) begin
        hold_check(n, 1 + int'($urandom % 25), "R5");
        fire_tx();
        run_check(n, fst, 0, "R5");
      end else begin
        run_check(n, fst, int'($urandom % 30), "R9");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule